// File: doc/BRIEF.md
# Asynchronous static RAM cycle controller

This block sits between an internal request port and an external asynchronous static RAM with 19 address bits, a shared 16-bit bidirectional data bus and separate lower and upper byte-lane enables. It takes one single-word read or write request at a time, through a valid/ready handshake. It then plays out a correctly timed cycle on the RAM pins and returns read data with a one-clock valid strobe.

All RAM pins come from registers. The RAM's timing limits are parameters in nanoseconds. The controller turns each limit into a clock-cycle count as ceiling(time / clock period), with a floor of one cycle. With the default 4 ns clock this gives:

- a read cycle of 14 clocks,
- a write pulse of 10 clocks,
- a write cycle of 14 clocks,
- a bus turnaround of 5 clocks.

Writes are timed by the write-enable pulse. The controller drives the data bus only while write-enable is low. After a read it waits out the RAM's output release time before it turns its own drivers on.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no request is in progress, the controller behaves as follows. req_ready is 1. The chip is deselected (ram_cs_n=1, ram_cs=0). ram_we_n, ram_oe_n, ram_lb_n and ram_ub_n are all 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 for exactly 14 clocks (the read cycle or write cycle count) before it returns to 1. The only exception is a write that waits for bus turnaround. For the whole span, ram_addr holds the request address and the chip is selected (ram_cs_n=0, ram_cs=1).
- R3: Byte-lane enables follow the request mask, which is active high. Mask bit 0 drives ram_lb_n low and selects data bits 7..0. Mask bit 1 drives ram_ub_n low and selects bits 15..8. During a write, ram_we_n is low for exactly 10 consecutive clocks, which is the larger of the write-pulse and data-setup counts. The controller drives ram_dq only while ram_we_n is low.
- R4: A write changes only the enabled byte lanes of the addressed word. A write with mask 0 leaves the word unchanged.
- R5: During a read, ram_oe_n is low for exactly 14 clocks, the larger of the address-access and output-enable counts, and ram_we_n stays 1. rd_valid rises 14 clocks after acceptance and is high for exactly one clock.
- R6: For a read, rd_data holds the addressed word in each lane whose mask bit is 1. A lane whose mask bit is 0 reads as 0.
- R7: After ram_oe_n rises, ram_we_n does not fall (so the controller does not drive the bus) for at least 5 clocks, the output release count.
- R8: ram_oe_n and ram_we_n are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane mask, bit 0 low lane, bit 1 high lane |
| rd_valid | output | 1 | One-clock read data strobe |
| rd_data | output | 16 | Read data |
| ram_addr | output | 19 | RAM address |
| ram_cs_n | output | 1 | Active-low chip select |
| ram_cs | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Active-low write enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_lb_n | output | 1 | Active-low lower byte-lane enable |
| ram_ub_n | output | 1 | Active-low upper byte-lane enable |
| ram_dq | inout | 16 | Shared RAM data bus |

## Verification
The assertions check the following on every cycle:

- the idle pin state;
- exclusion between output-enable and write-enable;
- the controller drives the bus only while write-enable is low;
- address, chip select and lane stability during a cycle;
- the single-clock read strobe;
- the turnaround counter being empty whenever a write pulse begins.

The pulse lengths, the 14-clock busy span and read latency, and the measured gap between a read's output-enable release and a following write can only be shown by the bench's scenarios. The same holds for the lane-selective effect of byte masks on stored data and on returned data. The bench sweeps sixteen addresses, including both ends of the address range, across all four mask values.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW     = 19,
  parameter int DW     = 16,
  parameter int CLK_NS = 4,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_OE   = 25,
  parameter int T_WP   = 40,
  parameter int T_WC   = 55,
  parameter int T_DW   = 25,
  parameter int T_OHZ  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_mask,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cs_n,
  output logic          ram_cs,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic          ram_lb_n,
  output logic          ram_ub_n,
  inout  wire  [DW-1:0] ram_dq
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_WP   = imax(cyc(T_WP), cyc(T_DW));
  localparam int N_WC   = imax(cyc(T_WC), N_WP + 1);
  localparam int N_RD   = imax(cyc(T_AA), cyc(T_OE));
  localparam int N_RC   = imax(cyc(T_RC), N_RD);
  localparam int N_TURN = cyc(T_OHZ);
  localparam int LW     = DW / 2;
  localparam int CW     = $clog2(N_WC + N_RC + N_TURN + 2);

  typedef enum logic [2:0] {IDLE, TURN, WR, RD, REC} st_t;

  st_t           st;
  logic [CW-1:0] cnt, turn_cnt;
  logic          is_wr, dq_oe;
  logic [DW-1:0] dq_out;

  assign req_ready = (st == IDLE);
  assign ram_dq    = dq_oe ? dq_out : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      turn_cnt <= '0;
      is_wr    <= 1'b0;
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ram_addr <= '0;
      ram_cs_n <= 1'b1;
      ram_cs   <= 1'b0;
      ram_we_n <= 1'b1;
      ram_oe_n <= 1'b1;
      ram_lb_n <= 1'b1;
      ram_ub_n <= 1'b1;
    end else begin
      rd_valid <= 1'b0;
      if (turn_cnt != '0) turn_cnt <= turn_cnt - 1'b1;
      case (st)
        IDLE: if (req_valid) begin
          ram_addr <= req_addr;
          ram_cs_n <= 1'b0;
          ram_cs   <= 1'b1;
          ram_lb_n <= ~req_mask[0];
          ram_ub_n <= ~req_mask[1];
          dq_out   <= req_wdata;
          is_wr    <= req_write;
          cnt      <= CW'(1);
          if (!req_write) begin
            ram_oe_n <= 1'b0;
            st       <= RD;
          end else if (turn_cnt != '0) begin
            st <= TURN;
          end else begin
            ram_we_n <= 1'b0;
            dq_oe    <= 1'b1;
            st       <= WR;
          end
        end
        TURN: if (turn_cnt == '0) begin
          ram_we_n <= 1'b0;
          dq_oe    <= 1'b1;
          st       <= WR;
        end
        WR: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(N_WP)) begin
            ram_we_n <= 1'b1;
            dq_oe    <= 1'b0;
            st       <= REC;
          end
        end
        RD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(N_RD)) begin
            rd_data  <= ram_dq & {{LW{~ram_ub_n}}, {LW{~ram_lb_n}}};
            rd_valid <= 1'b1;
            ram_oe_n <= 1'b1;
            turn_cnt <= CW'(N_TURN);
            if (N_RC > N_RD) st <= REC;
            else begin
              ram_cs_n <= 1'b1;
              ram_cs   <= 1'b0;
              ram_lb_n <= 1'b1;
              ram_ub_n <= 1'b1;
              st       <= IDLE;
            end
          end
        end
        REC: begin
          cnt <= cnt + 1'b1;
          if (cnt == (is_wr ? CW'(N_WC) : CW'(N_RC))) begin
            ram_cs_n <= 1'b1;
            ram_cs   <= 1'b0;
            ram_lb_n <= 1'b1;
            ram_ub_n <= 1'b1;
            st       <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && ram_lb_n && ram_ub_n));

  assert_hold_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> ($stable(ram_addr) && $stable(ram_lb_n) && $stable(ram_ub_n) && !ram_cs_n && ram_cs));

  assert_drive_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe == !ram_we_n);

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_turn_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> (turn_cnt == '0));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_oe_n && !ram_we_n));

endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int N_RC = 14, N_WC = 14, N_WP = 10, N_RD = 14, N_TURN = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rd_valid, ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n;
  logic [15:0] rd_data;
  logic [18:0] ram_addr;
  wire  [15:0] ram_dq;

  int checks = 0, errs = 0, cyc = 0, we_run = 0, oe_run = 0, oe_rise = -1000;
  bit prev_we = 1, prev_oe = 1, done = 0;
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  logic [15:0] mdrv;

  always #2 clk = ~clk;

  sram_async_ctrl u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rd_valid(rd_valid), .rd_data(rd_data), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n),
    .ram_cs(ram_cs), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_lb_n(ram_lb_n),
    .ram_ub_n(ram_ub_n), .ram_dq(ram_dq));

  wire sel = !ram_cs_n && ram_cs;
  always @(*) mdrv = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 16'h0;
  assign ram_dq[7:0]  = (sel && !ram_oe_n && ram_we_n && !ram_lb_n) ? mdrv[7:0]  : 8'hzz;
  assign ram_dq[15:8] = (sel && !ram_oe_n && ram_we_n && !ram_ub_n) ? mdrv[15:8] : 8'hzz;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [15:0] w;
    cyc++;
    if (sel && !ram_we_n) begin
      w = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 16'h0;
      if (!ram_lb_n) w[7:0] = ram_dq[7:0];
      if (!ram_ub_n) w[15:8] = ram_dq[15:8];
      mem[int'(ram_addr)] = w;
    end
    if (!ram_oe_n && !ram_we_n) chk(0, "R8", "oe_n and we_n both low", 0, 1);
    if (!ram_we_n && prev_we) chk(cyc - oe_rise >= N_TURN, "R7", "clocks from oe release to drive", cyc - oe_rise, N_TURN);
    if (ram_we_n && !prev_we) chk(we_run == N_WP, "R3", "we_n low clocks", we_run, N_WP);
    if (ram_oe_n && !prev_oe) begin
      chk(oe_run == N_RD, "R5", "oe_n low clocks", oe_run, N_RD);
      oe_rise = cyc;
    end
    we_run = ram_we_n ? 0 : we_run + 1;
    oe_run = ram_oe_n ? 0 : oe_run + 1;
    prev_we = ram_we_n;
    prev_oe = ram_oe_n;
  end

  task automatic run(input bit wr, input logic [18:0] a, input logic [15:0] d, input logic [1:0] m,
                     output int span, output int vlat, output logic [15:0] rdat);
    int n;
    bit held;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk); #1 req_valid = 0;
    n = 0; vlat = -1; rdat = 'x; held = 1;
    while (n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rd_valid) begin vlat = n; rdat = rd_data; end
      if (req_ready) break;
      if (ram_addr != a || ram_cs_n || !ram_cs || ram_lb_n != !m[0] || ram_ub_n != !m[1]) held = 0;
    end
    span = n;
    chk(held, "R2", "address, select and lanes held during cycle (R3 lanes)", held, 1);
    chk(ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && ram_lb_n && ram_ub_n, "R1", "idle pins after cycle",
        {ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n}, 6'b101111);
    if (!wr) begin
      @(negedge clk);
      chk(!rd_valid, "R5", "rd_valid single clock", rd_valid, 0);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [15:0] v, input logic [1:0] m);
    return v & {{8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic logic [18:0] addr_of(input int i);
    if (i == 0) return 19'h0;
    if (i == 15) return 19'h7FFFF;
    return 19'((i * 32'h9E37) ^ (i << 14));
  endfunction

  initial begin
    int sp, vl;
    logic [15:0] rv, e, d;
    logic [18:0] a;
    logic [1:0] m;
    repeat (3) @(negedge clk);
    chk(req_ready && ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && ram_lb_n && ram_ub_n, "R1", "reset state",
        {req_ready, ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n}, 7'b1101111);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      a = addr_of(i); d = 16'((a * 7) ^ 16'hA5C3);
      run(1, a, d, 2'b11, sp, vl, rv);
      shadow[int'(a)] = d;
      chk(sp == N_WC, "R2", "write busy span", sp, N_WC);
    end
    for (int i = 0; i < 16; i++) begin
      a = addr_of(i); m = 2'(i); d = 16'((a * 13) ^ 16'h3C5A ^ (i << 4));
      run(1, a, d, m, sp, vl, rv);
      e = shadow[int'(a)];
      if (m[0]) e[7:0] = d[7:0];
      if (m[1]) e[15:8] = d[15:8];
      shadow[int'(a)] = e;
    end
    for (int i = 0; i < 16; i++) begin
      a = addr_of(i);
      run(0, a, 16'h0, 2'b11, sp, vl, rv);
      chk(rv == shadow[int'(a)], "R4", "full read after masked write", rv, shadow[int'(a)]);
      chk(vl == N_RD, "R5", "read data latency", vl, N_RD);
      chk(sp == N_RC, "R2", "read busy span", sp, N_RC);
      m = 2'(i + 1);
      run(0, a, 16'h0, m, sp, vl, rv);
      e = lanes(shadow[int'(a)], m);
      chk(rv == e, "R6", "masked read lanes", rv, e);
      d = ~shadow[int'(a)];
      run(1, a, d, 2'b11, sp, vl, rv);
      chk(sp > N_WC, "R7", "write after read waits for turnaround", sp, N_WC + 1);
      shadow[int'(a)] = d;
      run(0, a, 16'h0, 2'b11, sp, vl, rv);
      chk(rv == d, "R4", "read back after turnaround write", rv, d);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R2", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule